// File: doc/BRIEF.md
# Two-Level Rotating Bus Arbiter

This block decides which of eight masters on a shared parallel bus may drive it next. Line 0 is the host-side controller inside the chip. Lines 1 to 7 serve the external masters, with line 7 serving external master 6 and line 1 serving external master 0. A configuration bit per line places the line in either the upper rotation or the lower group. The lower group as a whole takes a single turn in the upper rotation. When the group's turn comes, the group member that is next in its own rotation wins. Both rotations resume after the last winner they served.

The grant moves only while the bus is idle, which means no frame and no initiator-ready. The grant moves as soon as a different master is due, and it does not wait for the holder to give up. Between two different owners every grant line is low for at least one cycle. A forced mode lets the current holder keep the bus for as long as it holds its request. When no eligible master requests, the grant parks either on master 0 or on the last master that held the bus.

Each line has an enable bit. A line is also isolated automatically when it holds the grant while requesting and leaves the bus idle for a programmed number of cycles. Clearing the line's enable bit removes that automatic isolation. The status outputs show the current owner and the mask of isolated lines.

Top module: `arb2l_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `gnt` becomes all-zero and `stat_owner_vld` becomes 0, `stat_owner` becomes 0 and the automatic isolation state becomes empty, so `stat_iso` equals `~cfg_enable`.
- R2: `gnt` has at most one bit set. `gnt` keeps its value across any clock edge at which `frame_act` or `irdy_act` was high.
- R3: When `gnt` changes from one nonzero value to a different value, it passes through all-zero for at least one cycle.
- R4: Eligible requesters with `cfg_grp2` bit 0 are served in rotation. The search starts at the slot after the last upper-rotation winner. Slots 0..7 are the lines and slot 8 is the lower group. After reset the search starts at slot 0.
- R5: Eligible requesters with `cfg_grp2` bit 1 share upper slot 8. When slot 8 wins, the grant goes to the group member that follows the last group winner in index order, starting at line 0 after reset.
- R6: With `cfg_force` high, a holder whose request stays high and who is not isolated keeps the grant.
- R7: With no eligible request, the grant parks on line 0 when `cfg_park_last` is 0. When `cfg_park_last` is 1, it parks on the line that last received a grant, which is line 0 after reset. A parked line that is isolated is not granted. Parking does not move either rotation.
- R8: A line whose `cfg_enable` bit is 0 is never newly granted, and its `stat_iso` bit reads 1.
- R9: When `cfg_idle_limit` is nonzero, the bus is idle, and the holder requests for `cfg_idle_limit` consecutive cycles, that line becomes isolated at the last of those edges. The count restarts on any busy cycle, any cycle without a holder and any cycle in which the holder does not request. A limit of 0 disables the count. Driving the line's `cfg_enable` bit to 0 clears the isolation.
- R10: `stat_owner_vld` is 1 exactly when a grant is active, and `stat_owner` then gives the index of the granted line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 8 | Request per line |
| frame_act | input | 1 | Bus frame in progress |
| irdy_act | input | 1 | Initiator ready asserted |
| cfg_enable | input | 8 | Per-line enable; 0 isolates the line |
| cfg_grp2 | input | 8 | Per-line group select; 1 places the line in the lower group |
| cfg_park_last | input | 1 | Parking target: 1 for the last owner, 0 for line 0 |
| cfg_force | input | 1 | Forced mode: the holder keeps the bus while it requests |
| cfg_idle_limit | input | 8 | Idle cycles before automatic isolation; 0 disables it |
| gnt | output | 8 | One-hot grant |
| stat_owner | output | 3 | Index of the current owner |
| stat_owner_vld | output | 1 | A grant is active |
| stat_iso | output | 8 | Mask of isolated lines |

## Verification
Every grant decision is registered, so `gnt` and the owner status reflect the inputs sampled at the previous rising edge. A change of owner takes two edges: the grant falls at the first edge and the new grant rises at the next. An automatic isolation shows on `stat_iso` right after the edge that ends the idle count, and the new owner appears two edges after that. The bench drives inputs after a falling edge and advances its behavioural model at the rising edge. It compares every output at the following falling edge, so each expectation lands in the cycle where the registers have just moved.

// File: rtl/arb2l_pkg.sv
// Package: shared constants and helpers for the two-level arbiter.
// Assumes vectors of at most 32 lines.
package arb2l_pkg;

    // Line that receives the parked grant in default parking mode
    localparam int DEFAULT_PARK = 0;

    // Index of the lowest set bit; 0 when the vector is empty
    function automatic int low_index(input logic [31:0] vec);
        int res;
        res = 0;
        for (int i = 31; i >= 0; i--) begin
            if (vec[i]) res = i;
        end
        return res;
    endfunction

endpackage

// File: rtl/arb2l_rr_pick.sv
// Module: rotating picker. It selects the first set candidate after
// position `last`, wrapping around. Purely combinational.
// Assumes last < N.
module arb2l_rr_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         cand,
    input  logic [$clog2(N)-1:0] last,
    output logic                 hit,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // Scan from last+1 through last+N and keep the first candidate found
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 1; k <= N; k++) begin
            if (!hit && cand[(int'(last) + k) % N]) begin
                hit = 1'b1;
                idx = IW'((int'(last) + k) % N);
            end
        end
    end
endmodule

// File: rtl/arb2l_watch.sv
// Module: idle-holder watchdog. It counts idle cycles in which the current
// grant holder keeps requesting without starting a transaction, and marks
// the holder isolated when the programmed limit is reached. A cleared
// enable bit removes the mark.
// Assumes gnt is one-hot or zero.
module arb2l_watch #(
    parameter int N  = 8,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_idle,
    input  logic [N-1:0]  gnt,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  cfg_enable,
    input  logic [LW-1:0] limit,
    output logic [N-1:0]  auto_iso
);
    logic [LW-1:0] cnt;
    logic          active;
    logic          hit;

    // Count only while the holder requests on an idle bus with checking on
    always_comb begin
        active = bus_idle && (|(gnt & req)) && (limit != '0);
        hit    = active && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});
    end

    // Idle counter and sticky isolation marks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            auto_iso <= '0;
        end else begin
            cnt      <= (active && !hit) ? cnt + 1'b1 : '0;
            auto_iso <= (auto_iso | (hit ? gnt : '0)) & cfg_enable;
        end
    end

    // R9
    new_iso_on_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((auto_iso & ~$past(auto_iso)) & ~$past(gnt)) == '0);

    // R9
    busy_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(bus_idle) |-> cnt == '0);
endmodule

// File: rtl/arb2l_top.sv
// Module: two-level rotating bus arbiter with parking, forced mode and
// isolation of faulty masters. Line 0 is the host-side controller and the
// other lines serve external masters. The lower group takes the last slot
// of the upper rotation. Grants move only on an idle bus, and a dead cycle
// separates two different owners.
// Assumes N_LINES >= 2 and all inputs synchronous to clk.
module arb2l_top
    import arb2l_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int LIMIT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_LINES-1:0]         req,
    input  logic                       frame_act,
    input  logic                       irdy_act,
    input  logic [N_LINES-1:0]         cfg_enable,
    input  logic [N_LINES-1:0]         cfg_grp2,
    input  logic                       cfg_park_last,
    input  logic                       cfg_force,
    input  logic [LIMIT_W-1:0]         cfg_idle_limit,
    output logic [N_LINES-1:0]         gnt,
    output logic [$clog2(N_LINES)-1:0] stat_owner,
    output logic                       stat_owner_vld,
    output logic [N_LINES-1:0]         stat_iso
);
    localparam int N     = N_LINES;
    localparam int IW    = $clog2(N);
    localparam int SLOTS = N + 1;
    localparam int SW    = $clog2(SLOTS);
    localparam logic [SW-1:0] GROUP_SLOT = SW'(N);
    localparam logic [N-1:0]  ONE        = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0]  gnt_q;
    logic [IW-1:0] last_q;
    logic [SW-1:0] ptr1_q;
    logic [IW-1:0] ptr2_q;
    logic [N-1:0]  auto_iso;

    logic          bus_idle;
    logic [N-1:0]  iso_mask;
    logic [N-1:0]  elig;
    logic [N-1:0]  grp_req;
    logic [SW-1:0] l1_idx;
    logic          l1_hit;
    logic [IW-1:0] l2_idx;
    logic          l2_hit;
    logic [IW-1:0] arb_idx;
    logic [IW-1:0] park_idx;
    logic [N-1:0]  park_one;
    logic          force_keep;
    logic          from_arb;
    logic [N-1:0]  tgt;
    logic [IW-1:0] tgt_idx;

    // Bus state, isolation mask and eligible requests
    always_comb begin
        bus_idle = !frame_act && !irdy_act;
        iso_mask = ~cfg_enable | auto_iso;
        elig     = req & ~iso_mask;
        grp_req  = elig & cfg_grp2;
    end

    // Upper rotation: the lines outside the group plus one slot for the group
    arb2l_rr_pick #(.N(SLOTS)) u_pick_l1 (
        .cand ({|grp_req, elig & ~cfg_grp2}),
        .last (ptr1_q),
        .hit  (l1_hit),
        .idx  (l1_idx)
    );

    // Lower rotation among the group members
    arb2l_rr_pick #(.N(N)) u_pick_l2 (
        .cand (grp_req),
        .last (ptr2_q),
        .hit  (l2_hit),
        .idx  (l2_idx)
    );

    // Idle-holder watchdog that feeds the isolation mask
    arb2l_watch #(.N(N), .LW(LIMIT_W)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_idle   (bus_idle),
        .gnt        (gnt_q),
        .req        (req),
        .cfg_enable (cfg_enable),
        .limit      (cfg_idle_limit),
        .auto_iso   (auto_iso)
    );

    // Pick the target: forced hold, then rotation winner, then parking
    always_comb begin
        arb_idx    = (l1_idx == GROUP_SLOT) ? l2_idx : l1_idx[IW-1:0];
        park_idx   = cfg_park_last ? last_q : IW'(DEFAULT_PARK);
        park_one   = (ONE << park_idx) & ~iso_mask;
        force_keep = cfg_force && (|(gnt_q & elig));
        from_arb   = !force_keep && l1_hit;
        if (force_keep)  tgt = gnt_q;
        else if (l1_hit) tgt = ONE << arb_idx;
        else             tgt = park_one;
        tgt_idx    = l1_hit ? arb_idx : park_idx;
    end

    // Grant register: move only on an idle bus, with a dead cycle between owners
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            last_q <= '0;
            ptr1_q <= GROUP_SLOT;
            ptr2_q <= IW'(N - 1);
        end else if (bus_idle) begin
            if (gnt_q == '0) begin
                gnt_q <= tgt;
                if (tgt != '0) last_q <= tgt_idx;
                if (from_arb) begin
                    ptr1_q <= l1_idx;
                    if (l1_idx == GROUP_SLOT) ptr2_q <= l2_idx;
                end
            end else if (tgt != gnt_q) begin
                gnt_q <= '0;
            end
        end
    end

    // Status outputs
    always_comb begin
        gnt            = gnt_q;
        stat_owner_vld = |gnt_q;
        stat_owner     = IW'(low_index(32'(gnt_q)));
        stat_iso       = iso_mask;
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_q));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(bus_idle) |-> gnt_q == $past(gnt_q));

    // R3
    dead_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (|$past(gnt_q)) && (gnt_q != $past(gnt_q)) |-> gnt_q == '0);

    // R8
    no_iso_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((gnt_q & ~$past(gnt_q)) & $past(iso_mask)) == '0);

    // R6
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cfg_force) && $past(|(gnt_q & elig)) |-> gnt_q == $past(gnt_q));
endmodule

// File: tb/arb2l_top_tb_top.sv
// Bench: a behavioural model advanced at every rising edge and compared at
// every falling edge, plus directed checks of key values.
module arb2l_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic       frame_act = 1'b0;
    logic       irdy_act = 1'b0;
    logic [7:0] cfg_enable = 8'hFF;
    logic [7:0] cfg_grp2 = '0;
    logic       cfg_park_last = 1'b0;
    logic       cfg_force = 1'b0;
    logic [7:0] cfg_idle_limit = '0;
    logic [7:0] gnt;
    logic [2:0] stat_owner;
    logic       stat_owner_vld;
    logic [7:0] stat_iso;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;
    string tag = "R1";

    int m_gnt = -1;
    int m_last = 0;
    int m_p1 = 8;
    int m_p2 = 7;
    int m_cnt = 0;
    logic [7:0] m_auto = '0;

    arb2l_top dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .frame_act(frame_act), .irdy_act(irdy_act),
        .cfg_enable(cfg_enable), .cfg_grp2(cfg_grp2), .cfg_park_last(cfg_park_last),
        .cfg_force(cfg_force), .cfg_idle_limit(cfg_idle_limit), .gnt(gnt),
        .stat_owner(stat_owner), .stat_owner_vld(stat_owner_vld), .stat_iso(stat_iso)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic model_step();
        logic       idle;
        logic [7:0] en;
        logic [7:0] elig;
        int         tgt;
        int         gw;
        bit         arb;
        bit         keep;
        if (!rst_n) begin
            m_gnt = -1; m_last = 0; m_p1 = 8; m_p2 = 7; m_cnt = 0; m_auto = '0;
            return;
        end
        idle = !frame_act && !irdy_act;
        en   = cfg_enable & ~m_auto;
        elig = req & en;
        tgt  = -1; gw = -1; arb = 0;
        keep = cfg_force && m_gnt >= 0 && elig[m_gnt];
        if (keep) tgt = m_gnt;
        else if (elig != 0) begin
            arb = 1;
            for (int k = 1; k <= 9 && tgt < 0; k++) begin
                int s = (m_p1 + k) % 9;
                if (s < 8) begin
                    if (elig[s] && !cfg_grp2[s]) tgt = s;
                end else if ((elig & cfg_grp2) != 0) begin
                    for (int j = 1; j <= 8 && tgt < 0; j++) begin
                        int t = (m_p2 + j) % 8;
                        if (elig[t] && cfg_grp2[t]) begin tgt = t; gw = t; end
                    end
                end
            end
        end else begin
            int pk = cfg_park_last ? m_last : 0;
            if (en[pk]) tgt = pk;
        end
        // idle-holder count on the old state
        if (idle && m_gnt >= 0 && req[m_gnt] && cfg_idle_limit != 0) begin
            if (m_cnt + 1 >= int'(cfg_idle_limit)) begin
                m_auto[m_gnt] = 1'b1;
                m_cnt = 0;
            end else m_cnt++;
        end else m_cnt = 0;
        if (idle) begin
            if (m_gnt < 0) begin
                m_gnt = tgt;
                if (tgt >= 0) m_last = tgt;
                if (arb) begin
                    if (gw >= 0) begin m_p1 = 8; m_p2 = gw; end
                    else m_p1 = tgt;
                end
            end else if (tgt != m_gnt) m_gnt = -1;
        end
        m_auto = m_auto & cfg_enable;
    endtask

    task automatic compare();
        logic [7:0] eg;
        logic [7:0] ei;
        int         eo;
        eg = (m_gnt < 0) ? 8'h00 : 8'(1 << m_gnt);
        ei = ~cfg_enable | m_auto;
        eo = (m_gnt < 0) ? 0 : m_gnt;
        checks++;
        if (gnt !== eg || stat_iso !== ei || stat_owner_vld !== (m_gnt >= 0) || int'(stat_owner) != eo) begin
            failures++;
            $display("FAIL %s gnt=%b exp=%b iso=%b exp=%b owner=%0d/%b exp=%0d/%b", tag,
                     gnt, eg, stat_iso, ei, stat_owner, stat_owner_vld, eo, m_gnt >= 0);
        end
    endtask

    task automatic check_val(input string t, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", t, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic rand_busy(input int n, input bit rcfg);
        for (int i = 0; i < n; i++) begin
            req       = 8'($urandom);
            frame_act = ($urandom % 10) < 3;
            irdy_act  = ($urandom % 10) < 2;
            if (rcfg && (i % 40) == 0) begin
                cfg_grp2       = 8'($urandom);
                cfg_force      = ($urandom % 4) == 0;
                cfg_park_last  = 1'($urandom);
                cfg_enable     = 8'($urandom) | 8'h81;
                cfg_idle_limit = 8'($urandom % 5);
            end
            tick(1);
        end
    endtask

    initial begin
        tag = "R1";
        tick(3);
        check_val("R1 gnt in reset", gnt, 8'h00);
        check_val("R1 iso in reset", stat_iso, 8'h00);
        check_val("R1 owner_vld in reset", {7'b0, stat_owner_vld}, 8'h00);
        rst_n = 1'b1;

        tag = "R7";
        tick(1);
        check_val("R7 default park on line 0", gnt, 8'h01);
        tick(3);

        tag = "R4";
        req = 8'b0000_1110;
        tick(24);

        tag = "R5";
        cfg_grp2 = 8'hE0;
        req = 8'hE3;
        tick(40);

        tag = "R10";
        req = 8'h20;
        tick(4);
        check_val("R10 owner index", {5'b0, stat_owner}, 8'd5);

        tag = "R2";
        rand_busy(300, 0);
        frame_act = 0; irdy_act = 0;

        tag = "R3";
        cfg_grp2 = 8'h00;
        req = 8'h81;
        tick(20);

        tag = "R6";
        cfg_force = 1'b1;
        req = 8'h06;
        tick(12);
        req = 8'h04;
        tick(6);
        cfg_force = 1'b0;

        tag = "R7";
        cfg_park_last = 1'b1;
        req = 8'h10;
        tick(5);
        req = 8'h00;
        tick(5);
        check_val("R7 park on last owner", gnt, 8'h10);
        cfg_park_last = 1'b0;
        tick(4);
        check_val("R7 back to default park", gnt, 8'h01);

        tag = "R8";
        cfg_enable = 8'hFB;
        req = 8'h06;
        tick(30);
        check_val("R8 disabled line not granted", gnt & 8'h04, 8'h00);
        cfg_enable = 8'hFE;
        req = 8'h00;
        tick(4);
        check_val("R8 isolated park target", gnt, 8'h00);
        cfg_enable = 8'hFF;

        tag = "R9";
        cfg_idle_limit = 8'd3;
        req = 8'h08;
        tick(10);
        check_val("R9 auto isolation", stat_iso, 8'h08);
        cfg_enable = 8'hF7;
        tick(1);
        cfg_enable = 8'hFF;
        tick(1);
        check_val("R9 cleared by enable", stat_iso, 8'h00);
        cfg_idle_limit = 8'd0;
        tick(12);
        check_val("R9 limit zero disables", stat_iso, 8'h00);

        tag = "R10";
        rand_busy(1500, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule